// File: doc/BRIEF.md
# Option ROM Region Bank Selector

This block sits on the memory path of a 1 MB (20-bit) address space. For each access it decides what the target is: main RAM, display memory, one of several option ROM windows, a writable overlay RAM that replaces a ROM, a private expanded-memory RAM, or nothing. It returns a one-hot target code and a write enable for that access. An 8-bit select register turns the option windows on and off, one bit per window. A byte-coded command port sets and clears two flags. The overlay flag turns the two disk-interface ROM windows into RAM. The expanded-memory flag hands the 64 KB at B0000h–BFFFFh from display memory to a private RAM.

The decision is registered. An access presented on one clock edge gets its response on the next edge. The storage arrays, their boot-time contents and the display controller sit outside the block and act on the target code. When a read hits an unmapped address, the block tells the data path to return all-ones.

Top module: `orb_bank_sel`

## Requirements
- R1: A response is valid exactly one cycle after an access is presented. A valid response has exactly one bit set in the 12-bit target code, and an idle cycle gives an all-zero code. Target bit positions: 0 nothing, 1 main RAM, 2 display, 3 sound ROM, 4 SASI ROM, 5 SCSI ROM, 6 IDE ROM, 7 boot ROM, 8 SASI RAM, 9 SCSI RAM, 10 boot RAM, 11 expanded-memory RAM.
- R2: Main RAM answers 00000h–9FFFFh. Display memory answers A0000h–A4FFFh, A8000h–BFFFFh (unless R6 applies) and E0000h–E7FFFh. Both are writable. A5000h–A7FFFh goes to nothing.
- R3: Each option window maps its ROM only while its select bit is 1: sound CC000h–CFFFFh bit 7, SASI D7000h–D7FFFh bit 6, SCSI DC000h–DCFFFh bit 5, IDE D8000h–DBFFFh bit 4. A ROM target never gives a write enable. A window whose bit is 0 goes to nothing. Select bits 0, 2 and 3 have no effect.
- R4: Command code 12h sets the overlay flag and 10h clears it. While the flag is set, an enabled SASI or SCSI window targets its writable RAM. A disabled window stays at nothing whatever the flag holds.
- R5: The top 24 pages of 4 KB (E8000h–FFFFFh) target the read-only boot ROM when select bit 1 is 0, and the writable boot RAM when it is 1.
- R6: Command code 22h sets the expanded-memory flag and 20h clears it. While the flag is set, B0000h–BFFFFh targets the writable expanded-memory RAM. While it is clear, that range targets display memory.
- R7: An access to nothing never gives a write enable. When it is a read, the fill output asks for FFh; the fill output is low for every other response.
- R8: Reset clears the select register, the overlay flag and the expanded-memory flag. No response is valid while reset is held.
- R9: Command codes other than 10h, 12h, 20h and 22h change nothing. Repeating a code that is already in effect changes nothing.
- R10: A write to the select register or the command port affects accesses presented from the following cycle on. An access in the same cycle is decoded with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_we | input | 1 | Loads the select register |
| sel_wdata | input | 8 | New select register value |
| cmd_we | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Access byte address |
| acc_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response for last cycle's access |
| rsp_target | output | 12 | One-hot target code |
| rsp_wr_en | output | 1 | Write is committed to the target |
| rsp_fill | output | 1 | Read must return FFh |

## Verification
Every response is due on the first clock edge after its access. The bench drives each access on a falling edge and compares all four outputs on the next falling edge, so one access is retired per cycle. Settings changes only act on the cycle after they are written. They are applied with the access port idle, except in the R10 test, which puts a settings write and an access in the same cycle to show the old settings still apply. The sweep covers every 4 KB page under all 128 combinations of the five used select bits and both flags.

// File: rtl/orb_pkg.sv
package orb_pkg;

  localparam int NTGT = 12;
  localparam int TGW  = $clog2(NTGT);

  localparam int TG_NONE     = 0;
  localparam int TG_MAIN     = 1;
  localparam int TG_DISP     = 2;
  localparam int TG_ROM_SND  = 3;
  localparam int TG_ROM_SASI = 4;
  localparam int TG_ROM_SCSI = 5;
  localparam int TG_ROM_IDE  = 6;
  localparam int TG_ROM_BOOT = 7;
  localparam int TG_RAM_SASI = 8;
  localparam int TG_RAM_SCSI = 9;
  localparam int TG_RAM_BOOT = 10;
  localparam int TG_EMS      = 11;

  localparam logic [7:0] CMD_OVL_OFF = 8'h10;
  localparam logic [7:0] CMD_OVL_ON  = 8'h12;
  localparam logic [7:0] CMD_EMS_OFF = 8'h20;
  localparam logic [7:0] CMD_EMS_ON  = 8'h22;

  localparam int BOOT_SEL_BIT = 1;

  // page numbers (4 KB pages) in a 1 MB map
  localparam int MAIN_HI  = 'h9F;
  localparam int DISPA_LO = 'hA0;
  localparam int DISPA_HI = 'hA4;
  localparam int DISPB_LO = 'hA8;
  localparam int DISPB_HI = 'hBF;
  localparam int DISPE_LO = 'hE0;
  localparam int DISPE_HI = 'hE7;
  localparam int EMS_LO   = 'hB0;
  localparam int EMS_HI   = 'hBF;

  // option windows: sound, sasi, scsi, ide
  localparam int OPT_N = 4;
  localparam int OPT_LO  [OPT_N] = '{'hCC, 'hD7, 'hDC, 'hD8};
  localparam int OPT_HI  [OPT_N] = '{'hCF, 'hD7, 'hDC, 'hDB};
  localparam int OPT_BIT [OPT_N] = '{7, 6, 5, 4};
  localparam int OPT_ROM [OPT_N] = '{TG_ROM_SND, TG_ROM_SASI, TG_ROM_SCSI, TG_ROM_IDE};
  localparam int OPT_RAM [OPT_N] = '{TG_NONE, TG_RAM_SASI, TG_RAM_SCSI, TG_NONE};
  localparam bit OPT_OVL [OPT_N] = '{1'b0, 1'b1, 1'b1, 1'b0};

endpackage

// File: rtl/orb_ctrl.sv
module orb_ctrl
  import orb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_we,
  input  logic [7:0] sel_wdata,
  input  logic       cmd_we,
  input  logic [7:0] cmd_code,
  output logic [7:0] sel_q,
  output logic       ovl_q,
  output logic       ems_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      ovl_q <= 1'b0;
      ems_q <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (cmd_we) begin
        case (cmd_code)
          CMD_OVL_OFF: ovl_q <= 1'b0;
          CMD_OVL_ON:  ovl_q <= 1'b1;
          CMD_EMS_OFF: ems_q <= 1'b0;
          CMD_EMS_ON:  ems_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/orb_span.sv
module orb_span #(
  parameter int PW = 8,
  parameter int LO = 1,
  parameter int HI = 2
) (
  input  logic [PW-1:0] page,
  output logic          hit
);

  localparam int TOP = (1 << PW) - 1;

  generate
    if (LO == 0) begin : g_top_only
      assign hit = (page <= PW'(HI));
    end else if (HI >= TOP) begin : g_bot_only
      assign hit = (page >= PW'(LO));
    end else begin : g_both
      assign hit = (page >= PW'(LO)) && (page <= PW'(HI));
    end
  endgenerate

endmodule

// File: rtl/orb_decode.sv
module orb_decode
  import orb_pkg::*;
#(
  parameter int PW      = 8,
  parameter int BOOT_LO = 232
) (
  input  logic [PW-1:0]  page,
  input  logic [7:0]     sel,
  input  logic           ovl,
  input  logic           ems,
  output logic [TGW-1:0] tgt_idx,
  output logic           wr_ok
);

  localparam int TOP = (1 << PW) - 1;

  logic main_hit, dispa_hit, dispb_hit, dispe_hit, ems_hit, boot_hit;
  logic [OPT_N-1:0] opt_hit;
  logic unused_sel;

  assign unused_sel = ^{sel[3:2], sel[0]};

  orb_span #(.PW(PW), .LO(0),        .HI(MAIN_HI))  u_main  (.page(page), .hit(main_hit));
  orb_span #(.PW(PW), .LO(DISPA_LO), .HI(DISPA_HI)) u_dispa (.page(page), .hit(dispa_hit));
  orb_span #(.PW(PW), .LO(DISPB_LO), .HI(DISPB_HI)) u_dispb (.page(page), .hit(dispb_hit));
  orb_span #(.PW(PW), .LO(DISPE_LO), .HI(DISPE_HI)) u_dispe (.page(page), .hit(dispe_hit));
  orb_span #(.PW(PW), .LO(EMS_LO),   .HI(EMS_HI))   u_ems   (.page(page), .hit(ems_hit));
  orb_span #(.PW(PW), .LO(BOOT_LO),  .HI(TOP))      u_boot  (.page(page), .hit(boot_hit));

  generate
    for (genvar i = 0; i < OPT_N; i++) begin : g_opt
      orb_span #(.PW(PW), .LO(OPT_LO[i]), .HI(OPT_HI[i])) u_win (
        .page(page),
        .hit (opt_hit[i])
      );
    end
  endgenerate

  always_comb begin
    tgt_idx = TGW'(TG_NONE);
    wr_ok   = 1'b0;
    if (main_hit) begin
      tgt_idx = TGW'(TG_MAIN);
      wr_ok   = 1'b1;
    end else if (ems_hit && ems) begin
      tgt_idx = TGW'(TG_EMS);
      wr_ok   = 1'b1;
    end else if (dispa_hit || dispb_hit || dispe_hit) begin
      tgt_idx = TGW'(TG_DISP);
      wr_ok   = 1'b1;
    end else if (boot_hit) begin
      if (sel[BOOT_SEL_BIT]) begin
        tgt_idx = TGW'(TG_RAM_BOOT);
        wr_ok   = 1'b1;
      end else begin
        tgt_idx = TGW'(TG_ROM_BOOT);
      end
    end else begin
      for (int i = 0; i < OPT_N; i++) begin
        if (opt_hit[i] && sel[OPT_BIT[i]]) begin
          if (OPT_OVL[i] && ovl) begin
            tgt_idx = TGW'(OPT_RAM[i]);
            wr_ok   = 1'b1;
          end else begin
            tgt_idx = TGW'(OPT_ROM[i]);
          end
        end
      end
    end
  end

endmodule

// File: rtl/orb_bank_sel.sv
module orb_bank_sel
  import orb_pkg::*;
#(
  parameter int AW         = 20,
  parameter int PAGE_SH    = 12,
  parameter int BOOT_PAGES = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_we,
  input  logic [7:0]      sel_wdata,
  input  logic            cmd_we,
  input  logic [7:0]      cmd_code,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  input  logic            acc_write,
  output logic            rsp_valid,
  output logic [NTGT-1:0] rsp_target,
  output logic            rsp_wr_en,
  output logic            rsp_fill
);

  localparam int PW      = AW - PAGE_SH;
  localparam int BOOT_LO = (1 << PW) - BOOT_PAGES;

  logic [7:0]     sel_q;
  logic           ovl_q, ems_q;
  logic [TGW-1:0] tgt_idx;
  logic           wr_ok;
  logic           unused_low;

  assign unused_low = ^acc_addr[PAGE_SH-1:0];

  orb_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sel_we   (sel_we),
    .sel_wdata(sel_wdata),
    .cmd_we   (cmd_we),
    .cmd_code (cmd_code),
    .sel_q    (sel_q),
    .ovl_q    (ovl_q),
    .ems_q    (ems_q)
  );

  orb_decode #(.PW(PW), .BOOT_LO(BOOT_LO)) u_dec (
    .page   (acc_addr[AW-1:PAGE_SH]),
    .sel    (sel_q),
    .ovl    (ovl_q),
    .ems    (ems_q),
    .tgt_idx(tgt_idx),
    .wr_ok  (wr_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_target <= '0;
      rsp_wr_en  <= 1'b0;
      rsp_fill   <= 1'b0;
    end else begin
      rsp_valid  <= acc_valid;
      rsp_target <= acc_valid ? (NTGT'(1) << tgt_idx) : '0;
      rsp_wr_en  <= acc_valid && acc_write && wr_ok;
      rsp_fill   <= acc_valid && !acc_write && (tgt_idx == TGW'(TG_NONE));
    end
  end

endmodule

// File: rtl/orb_bank_sel_chk.sv
module orb_bank_sel_chk
  import orb_pkg::*;
#(
  parameter int AW      = 20,
  parameter int PAGE_SH = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            acc_valid,
  input logic [AW-1:0]   acc_addr,
  input logic            acc_write,
  input logic            rsp_valid,
  input logic [NTGT-1:0] rsp_target,
  input logic            rsp_wr_en,
  input logic            rsp_fill
);

  localparam int PW = AW - PAGE_SH;

  // R1
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_target) == 1);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_target == '0) && !rsp_wr_en && !rsp_fill);

  // R1
  one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  // R2
  main_ram_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (acc_addr[AW-1:PAGE_SH] <= PW'(MAIN_HI))) |=> rsp_target[TG_MAIN]);

  // R3
  rom_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (|rsp_target[TG_ROM_BOOT:TG_ROM_SND]) |-> !rsp_wr_en);

  // R6
  ems_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_target[TG_EMS] |-> ($past(acc_addr[AW-1:PAGE_SH]) >= PW'(EMS_LO)) &&
                           ($past(acc_addr[AW-1:PAGE_SH]) <= PW'(EMS_HI)) &&
                           (rsp_wr_en == $past(acc_write)));

  // R7
  fill_only_none_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fill |-> rsp_target[TG_NONE] && !rsp_wr_en && !$past(acc_write));

  // R7
  write_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_wr_en |-> $past(acc_write) && !rsp_target[TG_NONE]);

endmodule

bind orb_bank_sel orb_bank_sel_chk #(.AW(AW), .PAGE_SH(PAGE_SH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_write (acc_write),
  .rsp_valid (rsp_valid),
  .rsp_target(rsp_target),
  .rsp_wr_en (rsp_wr_en),
  .rsp_fill  (rsp_fill)
);

// File: tb/orb_bank_sel_test.sv
module orb_bank_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam int T_NONE = 0, T_MAIN = 1, T_DISP = 2, T_RSND = 3, T_RSASI = 4,
                 T_RSCSI = 5, T_RIDE = 6, T_RBOOT = 7, T_WSASI = 8, T_WSCSI = 9,
                 T_WBOOT = 10, T_EMS = 11;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel_we;
  logic [7:0]  sel_wdata;
  logic        cmd_we;
  logic [7:0]  cmd_code;
  logic        acc_valid;
  logic [19:0] acc_addr;
  logic        acc_write;
  logic        rsp_valid;
  logic [11:0] rsp_target;
  logic        rsp_wr_en;
  logic        rsp_fill;

  int   vectors = 0;
  int   fails   = 0;
  bit   done    = 1'b0;

  logic [7:0] m_sel;
  bit         m_ovl, m_ems;

  always #(CLK_PERIOD/2) clk = ~clk;

  orb_bank_sel uut (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .rsp_wr_en(rsp_wr_en), .rsp_fill(rsp_fill)
  );

  function automatic int exp_tgt(int pg, logic [7:0] s, bit o, bit e);
    if (pg < 'hA0) return T_MAIN;
    if (e && pg >= 'hB0 && pg <= 'hBF) return T_EMS;
    if ((pg >= 'hA0 && pg <= 'hA4) || (pg >= 'hA8 && pg <= 'hBF) ||
        (pg >= 'hE0 && pg <= 'hE7)) return T_DISP;
    if (pg >= 256 - 24) return s[1] ? T_WBOOT : T_RBOOT;
    if (pg >= 'hCC && pg <= 'hCF) return s[7] ? T_RSND : T_NONE;
    if (pg == 'hD7) return s[6] ? (o ? T_WSASI : T_RSASI) : T_NONE;
    if (pg == 'hDC) return s[5] ? (o ? T_WSCSI : T_RSCSI) : T_NONE;
    if (pg >= 'hD8 && pg <= 'hDB) return s[4] ? T_RIDE : T_NONE;
    return T_NONE;
  endfunction

  function automatic bit writable(int idx);
    return idx == T_MAIN || idx == T_DISP || idx == T_WSASI ||
           idx == T_WSCSI || idx == T_WBOOT || idx == T_EMS;
  endfunction

  function automatic string req_of(int idx, int pg);
    if (pg >= 'hB0 && pg <= 'hBF) return "R6";
    case (idx)
      T_MAIN, T_DISP:                    return "R2";
      T_RSND, T_RSASI, T_RSCSI, T_RIDE:  return "R3";
      T_WSASI, T_WSCSI:                  return "R4";
      T_RBOOT, T_WBOOT:                  return "R5";
      default:                           return "R7";
    endcase
  endfunction

  task automatic acc_chk(input logic [19:0] a, input bit wr, input int eidx, input string req);
    logic [11:0] et;
    bit ew, ef;
    acc_valid = 1'b1;
    acc_addr  = a;
    acc_write = wr;
    @(negedge clk);
    et = 12'(1) << eidx;
    ew = wr && writable(eidx);
    ef = !wr && (eidx == T_NONE);
    vectors++;
    if (rsp_valid !== 1'b1 || rsp_target !== et || rsp_wr_en !== ew || rsp_fill !== ef) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b actual v=%b t=%h w=%b f=%b expected v=1 t=%h w=%b f=%b",
               req, a, wr, rsp_valid, rsp_target, rsp_wr_en, rsp_fill, et, ew, ef);
    end
  endtask

  task automatic idle_chk(input string req);
    acc_valid = 1'b0;
    acc_write = 1'b0;
    @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0 || rsp_target !== 12'h000 || rsp_wr_en !== 1'b0 || rsp_fill !== 1'b0) begin
      fails++;
      $display("FAIL %s idle actual v=%b t=%h w=%b f=%b expected v=0 t=000 w=0 f=0",
               req, rsp_valid, rsp_target, rsp_wr_en, rsp_fill);
    end
  endtask

  task automatic set_sel(input logic [7:0] v);
    sel_we = 1'b1;
    sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
    m_sel = v;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    cmd_we = 1'b1;
    cmd_code = c;
    @(negedge clk);
    cmd_we = 1'b0;
    case (c)
      8'h10: m_ovl = 1'b0;
      8'h12: m_ovl = 1'b1;
      8'h20: m_ems = 1'b0;
      8'h22: m_ems = 1'b1;
      default: ;
    endcase
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
    report();
  end

  initial begin
    rst = 1'b1; sel_we = 1'b0; sel_wdata = 8'h00; cmd_we = 1'b0; cmd_code = 8'h00;
    acc_valid = 1'b1; acc_addr = 20'h00000; acc_write = 1'b0;
    m_sel = 8'h00; m_ovl = 1'b0; m_ems = 1'b0;

    // R8: nothing valid while reset is held
    repeat (3) @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8 in reset actual v=%b expected v=0", rsp_valid);
    end
    rst = 1'b0;
    idle_chk("R1");

    // R8: reset state of select register and flags
    acc_chk(20'hCC000, 1'b0, T_NONE,  "R8");
    acc_chk(20'hB0000, 1'b0, T_DISP,  "R8");
    acc_chk(20'hE8000, 1'b1, T_RBOOT, "R8");
    idle_chk("R1");
    set_sel(8'h40);
    acc_chk(20'hD7123, 1'b1, T_RSASI, "R8");
    idle_chk("R1");

    // R10: same-cycle settings write uses old settings
    sel_we = 1'b1; sel_wdata = 8'h60;
    acc_chk(20'hDC000, 1'b0, T_NONE, "R10");
    sel_we = 1'b0; m_sel = 8'h60;
    acc_chk(20'hDCFFF, 1'b0, T_RSCSI, "R10");
    cmd_we = 1'b1; cmd_code = 8'h22;
    acc_chk(20'hB4000, 1'b1, T_DISP, "R10");
    cmd_we = 1'b0; m_ems = 1'b1;
    acc_chk(20'hB4000, 1'b1, T_EMS, "R10");
    idle_chk("R1");
    send_cmd(8'h20);

    // R8: mid-run reset clears everything
    set_sel(8'hFF);
    send_cmd(8'h12);
    send_cmd(8'h22);
    acc_chk(20'hD7000, 1'b1, T_WSASI, "R4");
    acc_chk(20'hBFFFF, 1'b1, T_EMS,   "R6");
    acc_chk(20'hFFFFF, 1'b1, T_WBOOT, "R5");
    idle_chk("R1");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_sel = 8'h00; m_ovl = 1'b0; m_ems = 1'b0;
    acc_chk(20'hFFFFF, 1'b1, T_RBOOT, "R8");
    acc_chk(20'hBFFFF, 1'b1, T_DISP,  "R8");
    idle_chk("R1");
    set_sel(8'h60);
    acc_chk(20'hD7000, 1'b1, T_RSASI, "R8");
    acc_chk(20'hDC000, 1'b1, T_RSCSI, "R8");
    idle_chk("R1");

    // full sweep: every page under every combination of used bits and flags
    for (int cfg = 0; cfg < 128; cfg++) begin
      automatic logic [6:0] c = 7'(cfg);
      automatic logic [7:0] s = {c[0], c[1], c[2], c[3], c[2] ^ c[5], c[6], c[4], c[1] ^ c[6]};
      set_sel(s);
      send_cmd(c[5] ? 8'h12 : 8'h10);
      send_cmd(8'h55);                    // R9: unknown code
      send_cmd(c[6] ? 8'h22 : 8'h20);
      send_cmd(c[6] ? 8'h22 : 8'h20);     // R9: repeated code
      send_cmd(8'h21);                    // R9: unknown code
      for (int pg = 0; pg < 256; pg++) begin
        automatic logic [7:0]  p   = 8'(pg);
        automatic logic [11:0] off = p[0] ? 12'hFFF : 12'(pg * 173 + cfg * 7);
        automatic bit          wr  = p[1] ^ c[0];
        automatic int          e   = exp_tgt(pg, m_sel, m_ovl, m_ems);
        acc_chk({p, off}, wr, e, (cfg % 2 == 1 && pg == 'hD7) ? "R9" : req_of(e, pg));
      end
      idle_chk("R1");
    end

    report();
  end

endmodule